// File: doc/BRIEF.md
# Stereo Pan Mixer with Per-Side Phase Inversion

This block forms the left and right output sums of a multi-voice synthesizer once per sample frame. A frame starts with a one-cycle `frame_start` pulse. The block then walks the voices in index order, one voice per cycle, and names the voice it wants on `rd_ch` while `rd_active` is high. The source returns that voice's signed sample on `sample_in` in the same cycle, without a register.

For each voice the block works out two products: the sample times the left gain, and the sample times the right gain. Each product is divided exactly by 2288, with the quotient truncated toward zero. The result for a side is negated when that side's inversion bit is set for the voice. Both results go into running sums, and the finished 32-bit signed sums appear with a one-cycle `done` strobe.

Voices `0` to `NUM_CH-1` are the ordinary voices. Voice `NUM_CH` is the wavetable voice, and it has its own gain and inversion settings. A mute input per voice removes that voice from both sums. Settings are written through a byte-wide write port. Each voice has a block of `REGS_PER_CH` addresses.

Top module: `stereo_pan_mix`

## Requirements
- R1: After reset, `sum_l`, `sum_r`, `done` and `rd_active` are 0. Every voice then has left and right gains of 0xFF and an inversion setting of 0.
- R2: A `frame_start` sampled while `rd_active` is low has the following effect:
  - `rd_active` is high for the next `NUM_CH+1` cycles.
  - `rd_ch` reads 0, 1, … `NUM_CH` in those cycles.
  - `done` is high in the cycle `NUM_CH+2` clock edges after the one that sampled `frame_start`.
- R3: Each voice's share of a side's sum is the sample times that side's gain, divided by 2288 and truncated toward zero.
- R4: Bit 0 of a voice's inversion setting negates its share of the right sum. Bit 1 negates its share of the left sum.
- R5: A voice whose `ch_mute` bit is high in its read cycle adds nothing to either sum.
- R6: The wavetable voice (index `NUM_CH`) keeps an inversion setting of its own, with the same bit meaning as R4.
- R7: The write address map for voice k is as follows:
  - address k·4+0 sets the left gain;
  - k·4+1 sets the right gain;
  - k·4+2 sets the inversion setting, from `wr_data[1:0]` only.
  Offset 3, and any address at or above (`NUM_CH`+1)·4, change nothing.
- R8: A `frame_start` sampled while `rd_active` is high is ignored. The running frame keeps its voice order, its timing and its result.
- R9: `done` lasts one cycle. `sum_l` and `sum_r` change only in the cycle where `done` is high, and hold their values between frames.
- R10: Each frame's sums contain only the voices read in that frame. Nothing is carried over from earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Starts a frame when the block is idle |
| ch_mute | input | NUM_CH+1 | Per-voice mute, sampled in that voice's read cycle |
| wr_en | input | 1 | Settings write strobe |
| wr_addr | input | ADDR_W | Settings write address |
| wr_data | input | 8 | Settings write data |
| sample_in | input | SAMPLE_W | Signed sample of the voice named on `rd_ch` |
| rd_active | output | 1 | High while voices are being read |
| rd_ch | output | CH_W | Index of the voice being read |
| sum_l | output | ACC_W | Left sum of the last finished frame (signed) |
| sum_r | output | ACC_W | Right sum of the last finished frame (signed) |
| done | output | 1 | One-cycle strobe when new sums are presented |

## Verification
Call the clock edge that samples `frame_start` edge 0. Voice k is read in the cycle after edge k. The two pipeline registers then put `done` and the new sums in the cycle after edge `NUM_CH+2`. The bench drives inputs on falling edges and counts falling edges from edge 0. It checks `rd_ch` in every read cycle, checks that `done` is still low one cycle before it is due, and compares both sums in the exact cycle `done` rises. It then checks that `done` has dropped, and re-reads the sums several cycles later to confirm they are held. Settings writes are made only between frames, so each write takes effect in the next frame.

// File: rtl/spm_pkg.sv
// Shared constants and types for the stereo pan mixer.
// Assumes 8-bit gains and a 2-bit inversion setting per voice.
package spm_pkg;
    localparam int unsigned GAIN_W        = 8;
    localparam int unsigned INV_W         = 2;
    localparam int unsigned INV_RIGHT_BIT = 0;
    localparam int unsigned INV_LEFT_BIT  = 1;
    localparam int unsigned GAIN_DIVISOR  = 2288;
    localparam logic [GAIN_W-1:0] GAIN_RESET = 8'hFF;

    typedef struct packed {
        logic [GAIN_W-1:0] gain_l;
        logic [GAIN_W-1:0] gain_r;
        logic [INV_W-1:0]  flip;
    } voice_cfg_t;
endpackage

// File: rtl/spm_regs.sv
// Per-voice settings store: left gain, right gain and inversion bits.
// Assumes voice k owns addresses k*REGS_PER_CH + offset; unmatched writes are dropped.
module spm_regs
    import spm_pkg::*;
#(
    parameter int NVOICE      = 5,
    parameter int ADDR_W      = 8,
    parameter int REGS_PER_CH = 4,
    parameter int OFS_GAIN_L  = 0,
    parameter int OFS_GAIN_R  = 1,
    parameter int OFS_FLIP    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    output voice_cfg_t [NVOICE-1:0]  cfg_o
);
    for (genvar k = 0; k < NVOICE; k++) begin : g_voice
        localparam int BASE = k * REGS_PER_CH;
        logic       hit_l, hit_r, hit_f;
        voice_cfg_t cfg_q;

        assign hit_l = wr_en && (wr_addr == ADDR_W'(BASE + OFS_GAIN_L));
        assign hit_r = wr_en && (wr_addr == ADDR_W'(BASE + OFS_GAIN_R));
        assign hit_f = wr_en && (wr_addr == ADDR_W'(BASE + OFS_FLIP));

        // Hold this voice's settings, loading a field on an address match.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q.gain_l <= GAIN_RESET;
                cfg_q.gain_r <= GAIN_RESET;
                cfg_q.flip   <= '0;
            end else begin
                if (hit_l) cfg_q.gain_l <= wr_data;
                if (hit_r) cfg_q.gain_r <= wr_data;
                if (hit_f) cfg_q.flip   <= wr_data[INV_W-1:0];
            end
        end

        assign cfg_o[k] = cfg_q;
    end
endmodule

// File: rtl/spm_seq.sv
// Frame sequencer: on an accepted start, names each voice once, in index order.
// Assumes a start request while busy is dropped.
module spm_seq #(
    parameter int NVOICE = 5,
    parameter int CH_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    output logic            active_o,
    output logic [CH_W-1:0] ch_o,
    output logic            start_o,
    output logic            last_o
);
    logic            active_q;
    logic [CH_W-1:0] ch_q;
    logic            at_last;

    assign at_last  = (ch_q == CH_W'(NVOICE - 1));
    assign start_o  = frame_start && !active_q;
    assign last_o   = active_q && at_last;
    assign active_o = active_q;
    assign ch_o     = ch_q;

    // Step the voice index once per cycle from an accepted start to the last voice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ch_q     <= '0;
        end else if (start_o) begin
            active_q <= 1'b1;
            ch_q     <= '0;
        end else if (active_q) begin
            if (at_last) active_q <= 1'b0;
            else         ch_q     <= ch_q + 1'b1;
        end
    end
endmodule

// File: rtl/spm_lane.sv
// One output side: scale, exact divide with truncation toward zero, optional
// negation, and accumulation. Stage A holds |sample|*gain and the sign;
// stage B divides and adds. Assumes ACC_W > SAMPLE_W + GAIN_W.
module spm_lane
    import spm_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int ACC_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       take,
    input  logic                       take_last,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       mute,
    input  logic [GAIN_W-1:0]          gain,
    input  logic                       flip,
    output logic [ACC_W-1:0]           sum_o
);
    localparam int MAG_W = SAMPLE_W + GAIN_W;
    localparam int PAD_W = ACC_W - MAG_W;

    logic [SAMPLE_W-1:0]     mag_s;
    logic [MAG_W-1:0]        prod_q;
    logic                    neg_q, val_q, last_q;
    logic [MAG_W-1:0]        quo;
    logic signed [ACC_W-1:0] qext, share;
    logic signed [ACC_W-1:0] acc_q;

    // Magnitude of the sample; the most negative value maps onto 2^(SAMPLE_W-1).
    always_comb mag_s = sample[SAMPLE_W-1] ? SAMPLE_W'(~sample + 1'b1) : SAMPLE_W'(sample);

    // Stage A: capture the unsigned product and the final sign of this voice's share.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            neg_q  <= 1'b0;
            val_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            val_q  <= take;
            last_q <= take_last;
            if (take) begin
                prod_q <= mute ? '0 : MAG_W'(mag_s) * MAG_W'(gain);
                neg_q  <= sample[SAMPLE_W-1] ^ flip;
            end
        end
    end

    // Stage B arithmetic: divide the magnitude, then apply the sign.
    always_comb begin
        quo   = prod_q / MAG_W'(GAIN_DIVISOR);
        qext  = $signed({{PAD_W{1'b0}}, quo});
        share = neg_q ? -qext : qext;
    end

    // Stage B: clear at frame start, add each share, publish on the last voice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            sum_o <= '0;
        end else begin
            if (clear)       acc_q <= '0;
            else if (val_q)  acc_q <= acc_q + share;
            if (val_q && last_q) sum_o <= acc_q + share;
        end
    end
endmodule

// File: rtl/stereo_pan_mix.sv
// Top of the stereo pan mixer. It reads every voice once per frame, sends the
// selected voice's settings to a left and a right lane, and strobes done when
// both sums are final. Assumes sample_in is valid in the cycle rd_ch names.
module stereo_pan_mix
    import spm_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SAMPLE_W    = 18,
    parameter int ACC_W       = 32,
    parameter int ADDR_W      = 8,
    parameter int REGS_PER_CH = 4,
    parameter int CH_W        = $clog2(NUM_CH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic [NUM_CH:0]            ch_mute,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    output logic                       rd_active,
    output logic [CH_W-1:0]            rd_ch,
    output logic [ACC_W-1:0]           sum_l,
    output logic [ACC_W-1:0]           sum_r,
    output logic                       done
);
    localparam int NVOICE = NUM_CH + 1;

    voice_cfg_t [NVOICE-1:0] cfg;
    voice_cfg_t              cur;
    logic                    cur_mute;
    logic                    start, last;
    logic                    last_d1;
    logic [1:0][ACC_W-1:0]   sums;

    spm_regs #(
        .NVOICE(NVOICE), .ADDR_W(ADDR_W), .REGS_PER_CH(REGS_PER_CH),
        .OFS_GAIN_L(0), .OFS_GAIN_R(1), .OFS_FLIP(2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_o(cfg)
    );

    spm_seq #(.NVOICE(NVOICE), .CH_W(CH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .active_o(rd_active), .ch_o(rd_ch), .start_o(start), .last_o(last)
    );

    // Pick the settings and mute bit of the voice being read.
    always_comb begin
        cur      = '0;
        cur_mute = 1'b0;
        for (int k = 0; k < NVOICE; k++) begin
            if (rd_ch == CH_W'(k)) begin
                cur      = cfg[k];
                cur_mute = ch_mute[k];
            end
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int FLIP_BIT = (s == 0) ? INV_LEFT_BIT : INV_RIGHT_BIT;
        spm_lane #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .clear(start), .take(rd_active),
            .take_last(last), .sample(sample_in), .mute(cur_mute),
            .gain((s == 0) ? cur.gain_l : cur.gain_r),
            .flip(cur.flip[FLIP_BIT]), .sum_o(sums[s])
        );
    end

    assign sum_l = sums[0];
    assign sum_r = sums[1];

    // Delay the last-voice marker through both lane stages to form done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_d1 <= 1'b0;
            done    <= 1'b0;
        end else begin
            last_d1 <= last;
            done    <= last_d1;
        end
    end
endmodule

// File: rtl/spm_chk.sv
// Timing checker for stereo_pan_mix, attached by bind. Sees the ports only.
module spm_chk #(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 3,
    parameter int ACC_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             rd_active,
    input logic [CH_W-1:0]  rd_ch,
    input logic [ACC_W-1:0] sum_l,
    input logic [ACC_W-1:0] sum_r,
    input logic             done
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH);

    // R2
    first_voice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !rd_active) |=> (rd_active && rd_ch == '0));

    // R2
    voice_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> (rd_ch <= LAST));

    // R8: the index keeps stepping even if a new start arrives mid-frame
    voice_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && rd_ch != LAST) |=> (rd_active && rd_ch == CH_W'($past(rd_ch) + 1'b1)));

    // R2
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && rd_ch == LAST) |=> (!rd_active ##1 done));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    sums_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(sum_l) && $stable(sum_r)));
endmodule

bind stereo_pan_mix spm_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rd_active(rd_active),
    .rd_ch(rd_ch), .sum_l(sum_l), .sum_r(sum_r), .done(done)
);

// File: tb/stereo_pan_mix_tb.sv
module stereo_pan_mix_tb;
    localparam int NV = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_start = 1'b0;
    logic [NV-1:0]      mute = '0;
    logic               wr_en = 1'b0;
    logic [7:0]         wr_addr = '0;
    logic [7:0]         wr_data = '0;
    logic signed [17:0] sample_in;
    logic               rd_active;
    logic [2:0]         rd_ch;
    logic [31:0]        sum_l, sum_r;
    logic               done;

    logic signed [17:0] samp [NV];
    int                 gl [NV];
    int                 gr [NV];
    int                 fl [NV];
    int                 n_chk = 0;
    int                 n_err = 0;

    always #5 clk = ~clk;

    assign sample_in = (int'(rd_ch) < NV) ? samp[int'(rd_ch)] : '0;

    stereo_pan_mix u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_mute(mute),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sample_in(sample_in),
        .rd_active(rd_active), .rd_ch(rd_ch), .sum_l(sum_l), .sum_r(sum_r), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input bit right);
        longint t = 0;
        for (int k = 0; k < NV; k++) begin
            if (!mute[k]) begin
                longint q = (longint'(samp[k]) * longint'(right ? gr[k] : gl[k])) / 2288;
                bit f = right ? fl[k][0] : fl[k][1];
                t += f ? -q : q;
            end
        end
        return t[31:0];
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[7:0]; wr_data = d[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_voice(input int k, input int l, input int r, input int f);
        wr(k * 4 + 0, l); gl[k] = l;
        wr(k * 4 + 1, r); gr[k] = r;
        wr(k * 4 + 2, f); fl[k] = f & 3;
    endtask

    task automatic load_samples(input int set);
        for (int k = 0; k < NV; k++)
            samp[k] = 18'(((set * 37719 + k * 91807 + 5) % 262144) - 131072);
    endtask

    task automatic run_frame(input string tag, input bit mid_start);
        logic [31:0] el, er;
        el = model(1'b0);
        er = model(1'b1);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        chk(rd_active && rd_ch == 0, {tag, " R2 first voice"}, rd_ch, 0);
        for (int k = 1; k < NV; k++) begin
            if (mid_start) frame_start = (k == 2);
            @(negedge clk);
            chk(rd_active && int'(rd_ch) == k, {tag, " R2 voice order"}, rd_ch, k);
        end
        frame_start = 1'b0;
        @(negedge clk);
        chk(!done && !rd_active, {tag, " R2 done not early"}, done, 0);
        @(negedge clk);
        chk(done == 1'b1, {tag, " R2 done due"}, done, 1);
        chk(sum_l == el, {tag, " R3 R10 left sum"}, $signed(sum_l), $signed(el));
        chk(sum_r == er, {tag, " R3 R10 right sum"}, $signed(sum_r), $signed(er));
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < NV; k++) begin gl[k] = 255; gr[k] = 255; fl[k] = 0; end
        samp[0] = 18'sd131071; samp[1] = -18'sd131072; samp[2] = -18'sd1;
        samp[3] = 18'sd2287;   samp[4] = -18'sd9;
        repeat (3) @(negedge clk);
        chk(sum_l == 0 && sum_r == 0, "R1 reset sums", sum_l, 0);
        chk(!done && !rd_active, "R1 reset strobes", {done, rd_active}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset gains 0xFF and inversion 0 show in the first result
        run_frame("R1 defaults", 1'b0);

        // R4 R6: every inversion value on every voice, varied gains and samples
        for (int iv = 0; iv < 4; iv++) begin
            for (int s = 0; s < 3; s++) begin
                for (int k = 0; k < NV; k++)
                    set_voice(k, (k * 53 + iv * 17 + s * 29 + 1) & 255,
                              (k * 91 + iv * 41 + s * 7 + 3) & 255, (iv + k) % 4);
                load_samples(iv * 3 + s);
                run_frame("R4 R6 inversion sweep", 1'b0);
            end
        end

        // R3: gain boundaries against extreme samples
        samp[0] = 18'sd131071; samp[1] = -18'sd131072; samp[2] = 18'sd1;
        samp[3] = -18'sd2288;  samp[4] = 18'sd2288;
        set_voice(0, 0, 255, 0); set_voice(1, 1, 128, 1); set_voice(2, 128, 127, 2);
        set_voice(3, 255, 1, 3); set_voice(4, 127, 0, 0);
        run_frame("R3 gain edges", 1'b0);
        set_voice(0, 255, 255, 3); set_voice(1, 255, 255, 0); set_voice(3, 1, 1, 0);
        run_frame("R3 truncation", 1'b0);

        // R5: mute patterns
        load_samples(21);
        mute = 5'b10101; run_frame("R5 mute odd", 1'b0);
        mute = 5'b01010; run_frame("R5 mute even", 1'b0);
        mute = 5'b11111; run_frame("R5 mute all", 1'b0);
        mute = '0;

        // R6: only the wavetable voice flips
        for (int k = 0; k < NV; k++) set_voice(k, 200, 150, 0);
        set_voice(4, 200, 150, 1); run_frame("R6 wavetable right", 1'b0);
        set_voice(4, 200, 150, 2); run_frame("R6 wavetable left", 1'b0);

        // R7: unused offset, out-of-map addresses and upper inversion bits
        wr(3, 8'h00); wr(7, 8'h00); wr(20, 8'h00); wr(23, 8'h12); wr(255, 8'h00);
        wr(2, 8'hFE); fl[0] = 2;
        run_frame("R7 address map", 1'b0);

        // R8: a start pulse in the middle of a frame
        load_samples(33);
        run_frame("R8 mid-frame start", 1'b1);

        // R9 R10: held sums, then a fresh frame that ignores the last one
        repeat (6) @(negedge clk);
        chk(sum_l == model(1'b0) && sum_r == model(1'b1), "R9 sums held",
            $signed(sum_l), $signed(model(1'b0)));
        load_samples(40);
        run_frame("R10 fresh frame", 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule